// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Controller

This controller moves one byte at a time over a four-wire serial bus, either as the clocking side (master) or the clocked side (slave). Software reaches it through three byte-wide registers on a small synchronous register port: a mode register, a status register and a data register.

In master mode, a write to the data register loads the shift register and starts eight bit exchanges. The serial clock is derived from the peripheral clock by a divisor, a power of two, chosen by a 3-bit code. In slave mode, the same write only preloads the byte to send. The external master's clock, select and data pins are then brought into the clock domain through synchronizers.

Idle clock level and sampling edge are programmable, covering all four polarity/phase combinations. With phase mode 1, a slave can be told to ignore its select pin. When a byte completes, a flag is raised in the status register. Software clears it with a read of the status register followed by an access to the data register.

Top module: `spi_port`

## Requirements
- R1: After reset, the mode register and status register both read 0x00, and `sck_o` is low.
- R2: Mode bit 4 set selects master mode, in which a data-register write starts a transfer on `sck_o`. With bit 4 clear, a data-register write does not move `sck_o` off its idle level.
- R3: The rate code is {mode bit 6, mode bits 1:0}. Codes 0 to 6 give an SCK period of 2, 4, 8, 16, 32, 64 or 128 clock cycles, so each half period is 2^code cycles. Code 7 behaves like code 6.
- R4: Mode bit 3 (polarity) is the SCK level while no transfer runs.
- R5: Data is sent MSB first. With mode bit 2 (phase) clear, the first bit is on `sdo_o` before the first SCK edge, input is sampled on odd-numbered SCK edges (1st, 3rd, …), and output changes on even-numbered edges. With phase set, output changes on odd-numbered edges and input is sampled on even-numbered edges.
- R6: A master transfer has exactly 16 SCK edges, ends with SCK back at its idle level, and leaves the received byte readable from the data register.
- R7: Status bit 7 is set when the eighth bit has been exchanged. The other status bits read 0.
- R8: Status bit 7 clears only after a status read that sees it set, followed by a read or write of the data register. A data access without that prior status read leaves the flag set.
- R9: In slave mode with `ss_ni` low, the preloaded byte is shifted out on `sdo_o` and the byte received on `sdi_i` becomes readable from the data register.
- R10: With mode bit 5 (select ignore) and phase both set, a slave exchanges bytes while `ss_ni` is high.
- R11: With phase clear, mode bit 5 has no effect. A slave whose `ss_ni` is high takes no bits, the flag stays clear, and the data register still holds the preload.
- R12: If `ss_ni` rises in the middle of a byte while the select pin is honoured, that byte is dropped without setting the flag, and the next full byte is received correctly.
- R13: The register addresses are mode = 0, status = 1 and data = 2. Mode bits 6:0 read back as written, and mode bit 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock from an external master |
| ss_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data into the shift register |
| sdo_o | output | 1 | Serial data out of the shift register |

## Verification
Some properties are checked on every cycle by assertions:
- the clock returns to its programmed idle level whenever no master transfer runs;
- a master transfer starts only from a data write;
- a deselected slave never completes a byte;
- the flag rises on completion and falls only after the two-step clear.

Other behaviour can only be shown by the bench's scenarios, because each depends on whole bit sequences on the pins:
- the measured SCK half period for each rate code;
- MSB-first ordering and edge choice in all four modes;
- byte exchange with a modelled remote side;
- the select-ignore cases;
- recovery after an aborted byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // mode register image, bit 6 down to bit 0
  typedef struct packed {
    logic       rate_hi;
    logic       ss_ign;
    logic       master;
    logic       pol;
    logic       pha;
    logic [1:0] rate_lo;
  } ctrl_t;
endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic              data_wr_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  flag_q, armed_q;
  logic  data_acc, stat_rd;

  assign data_acc  = (wr_i || rd_i) && (addr_i == ADDR_DATA);
  assign data_wr_o = wr_i && (addr_i == ADDR_DATA);
  assign stat_rd   = rd_i && (addr_i == ADDR_STAT);
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && addr_i == ADDR_CTRL) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // two-step clear: status read seeing the flag arms, data access clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (done_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (data_acc && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: rdata_o = {flag_q, {(DW-1){1'b0}}};
      ADDR_DATA: rdata_o = rx_data_i;
      default:   rdata_o = '0;
    endcase
  end

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(data_acc && armed_q));
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [RW-1:0] code_i,
  input  logic          pol_i,
  output logic          sck_o,
  output logic          tick_o
);
  localparam int MAX_CODE = (1 << RW) - 2;
  localparam int HALF_W   = MAX_CODE + 1;

  logic [RW-1:0]     eff_code;
  logic [HALF_W-1:0] half_m1, cnt_q;
  logic              sck_q;

  assign eff_code = (code_i > RW'(MAX_CODE)) ? RW'(MAX_CODE) : code_i;
  assign half_m1  = (HALF_W'(1) << eff_code) - HALF_W'(1);
  assign tick_o   = run_i && (cnt_q == half_m1);
  assign sck_o    = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= pol_i;
    end else if (tick_o) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sck_q == $past(pol_i)));
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
  import spi_port_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          pha_i,
  input  logic          pol_i,
  input  logic          ss_ign_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          m_tick_i,
  input  logic          m_sck_i,
  input  logic          sck_i,
  input  logic          ss_ni,
  input  logic          sdi_i,
  output logic [DW-1:0] shreg_o,
  output logic          sdo_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic [SYNC_STAGES-1:0][2:0] sync_q;
  logic [DW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic samp_q, out_q, busy_q, s_sck_q;
  logic sck_s, ss_s, sdi_s, ss_in_use, sel;
  logic s_edge, m_edge, ev_edge, ev_lead, trail, din, abort, load_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{3'b010}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], {sck_i, ss_ni, sdi_i}};
  end

  assign {sck_s, ss_s, sdi_s} = sync_q[SYNC_STAGES-1];

  // select-ignore only counts in phase mode 1
  assign ss_in_use = !(ss_ign_i && pha_i);
  assign sel       = !ss_s || !ss_in_use;
  assign s_edge    = !master_i && sel && (sck_s != s_sck_q);
  assign m_edge    = master_i && busy_q && m_tick_i;
  assign ev_edge   = s_edge || m_edge;
  assign ev_lead   = master_i ? (m_sck_i == pol_i) : (s_sck_q == pol_i);
  assign din       = master_i ? sdi_i : sdi_s;
  assign trail     = ev_edge && !ev_lead;
  assign done_o    = trail && (cnt_q == LAST_BIT);
  assign abort     = !master_i && ss_in_use && ss_s && (cnt_q != '0);
  assign load_ok   = load_i && !(master_i && busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      samp_q  <= 1'b0;
      out_q   <= 1'b0;
      busy_q  <= 1'b0;
      s_sck_q <= 1'b0;
    end else begin
      s_sck_q <= sck_s;
      if (load_ok) begin
        sh_q   <= load_data_i;
        out_q  <= load_data_i[DW-1];
        cnt_q  <= '0;
        busy_q <= master_i;
      end else if (abort) begin
        cnt_q <= '0;
      end else if (ev_edge) begin
        if (ev_lead) begin
          samp_q <= din;
          out_q  <= sh_q[DW-1];
        end else begin
          sh_q  <= {sh_q[DW-2:0], pha_i ? din : samp_q};
          cnt_q <= cnt_q + CNT_W'(1);
          if (done_o) busy_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o   = pha_i ? out_q : sh_q[DW-1];
  assign shreg_o = sh_q;
  assign busy_o  = busy_q;

  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(load_i && master_i));

  assert_abort_no_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && ss_in_use && ss_s) |-> !done_o);

  assert_master_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && master_i) |-> busy_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o
);
  ctrl_t             ctrl;
  logic              data_wr, done, busy, tick, m_sck;
  logic [DATA_W-1:0] shreg;

  spi_port_regs #(.DW(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rx_data_i (shreg),
    .done_i    (done),
    .ctrl_o    (ctrl),
    .data_wr_o (data_wr),
    .rdata_o   (reg_rdata_o)
  );

  spi_port_clkgen #(.RW(RATE_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .code_i ({ctrl.rate_hi, ctrl.rate_lo}),
    .pol_i  (ctrl.pol),
    .sck_o  (m_sck),
    .tick_o (tick)
  );

  spi_port_shifter #(.DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (ctrl.master),
    .pha_i       (ctrl.pha),
    .pol_i       (ctrl.pol),
    .ss_ign_i    (ctrl.ss_ign),
    .load_i      (data_wr),
    .load_data_i (reg_wdata_i),
    .m_tick_i    (tick),
    .m_sck_i     (m_sck),
    .sck_i       (sck_i),
    .ss_ni       (ss_ni),
    .sdi_i       (sdi_i),
    .shreg_o     (shreg),
    .sdo_o       (sdo_o),
    .busy_o      (busy),
    .done_o      (done)
  );

  assign sck_o = m_sck;
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_o, sdo;
  logic       sck_in = 1'b0, ss_n = 1'b1, sdi = 1'b0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port u_spi_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck_o), .sck_i(sck_in), .ss_ni(ss_n), .sdi_i(sdi), .sdo_o(sdo)
  );

  function automatic int exp_half(input int code);
    return (code >= 6) ? 64 : (1 << code);
  endfunction

  function automatic logic [7:0] mode_byte(input logic [2:0] code, input logic ign,
                                           input logic mst, input logic pol, input logic pha);
    return {1'b0, code[2], ign, mst, pol, pha, code[1:0]};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic master_xfer(input logic [2:0] code, input logic pol, input logic pha,
                             input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] srx, r;
    time t0;
    srx = '0;
    t0 = 0;
    reg_write(2'd0, mode_byte(code, 1'b0, 1'b1, pol, pha));
    sdi = pha ? 1'b0 : stx[7];
    repeat (2) @(negedge clk);
    check(sck_o == pol, "R4 idle level", int'(sck_o), int'(pol));
    fork
      begin
        reg_write(2'd2, tx);
        if (!pha) check(sdo == tx[7], "R5 first bit before edge", int'(sdo), int'(tx[7]));
      end
      begin
        for (int k = 0; k < 16; k++) begin
          @(sck_o);
          if (k == 0) t0 = $time;
          if (k == 1) check(($time - t0) == exp_half(int'(code)) * CLK_PERIOD,
                            "R3 half period", int'($time - t0), exp_half(int'(code)) * CLK_PERIOD);
          #1;
          if (!pha) begin
            if (k % 2 == 0) srx = {srx[6:0], sdo};
            else if (k / 2 < 7) sdi = stx[6 - k/2];
          end else begin
            if (k % 2 == 0) sdi = stx[7 - k/2];
            else srx = {srx[6:0], sdo};
          end
        end
      end
    join
    repeat (4) @(negedge clk);
    check(sck_o == pol, "R6 sck back idle", int'(sck_o), int'(pol));
    check(srx == tx, "R5 MSB-first output", int'(srx), int'(tx));
    reg_read(2'd2, r);
    check(r == stx, "R6 received byte", int'(r), int'(stx));
    reg_read(2'd1, r);
    check(r == 8'h80, "R7 flag set, R8 kept after unarmed access", int'(r), 8'h80);
    reg_read(2'd2, r);
    reg_read(2'd1, r);
    check(r == 8'h00, "R8 flag cleared", int'(r), 0);
  endtask

  task automatic slave_xfer(input logic pol, input logic pha, input logic ign,
                            input logic use_ss, input logic [7:0] mtx,
                            input logic [7:0] stx, input int nbits,
                            output logic [7:0] srx);
    srx = '0;
    sck_in = pol;
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    reg_write(2'd0, mode_byte(3'd0, ign, 1'b0, pol, pha));
    reg_write(2'd2, stx);
    repeat (20) @(negedge clk);
    check(sck_o == pol, "R2 slave leaves sck idle", int'(sck_o), int'(pol));
    if (use_ss) ss_n = 1'b0;
    if (!pha) sdi = mtx[7];
    repeat (SH) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      if (!pha) begin
        srx = {srx[6:0], sdo};
        sck_in = ~pol;
        repeat (SH) @(negedge clk);
        sck_in = pol;
        if (b < 7) sdi = mtx[6 - b];
        repeat (SH) @(negedge clk);
      end else begin
        sck_in = ~pol;
        sdi = mtx[7 - b];
        repeat (SH) @(negedge clk);
        srx = {srx[6:0], sdo};
        sck_in = pol;
        repeat (SH) @(negedge clk);
      end
    end
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, srx, m, s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_read(2'd0, r);
    check(r == 8'h00, "R1 mode reset", int'(r), 0);
    reg_read(2'd1, r);
    check(r == 8'h00, "R1 status reset", int'(r), 0);
    check(sck_o == 1'b0, "R1 sck reset", int'(sck_o), 0);

    // R13 register map
    reg_write(2'd0, 8'h6D);
    reg_read(2'd0, r);
    check(r == 8'h6D, "R13 mode readback", int'(r), 8'h6D);
    reg_write(2'd0, 8'hFF);
    reg_read(2'd0, r);
    check(r == 8'h7F, "R13 bit7 reads zero", int'(r), 8'h7F);
    reg_write(2'd0, 8'h00);

    // R3/R5/R6 directed corner codes, then random master transfers
    master_xfer(3'd0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    master_xfer(3'd7, 1'b1, 1'b1, 8'h81, 8'h7E);
    for (int i = 0; i < 10; i++) begin
      master_xfer(3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
                  1'($urandom_range(1, 0)), 8'($urandom_range(255, 0)),
                  8'($urandom_range(255, 0)));
    end

    // R9 slave in every mode
    for (int md = 0; md < 4; md++) begin
      m = 8'($urandom_range(255, 0));
      s = 8'($urandom_range(255, 0));
      slave_xfer(1'(md >> 1), 1'(md & 1), 1'b0, 1'b1, m, s, 8, srx);
      check(srx == s, "R9 slave output", int'(srx), int'(s));
      reg_read(2'd1, r);
      check(r == 8'h80, "R9 slave flag", int'(r), 8'h80);
      reg_read(2'd2, r);
      check(r == m, "R9 slave received", int'(r), int'(m));
    end

    // R10 select ignored in phase 1
    slave_xfer(1'b1, 1'b1, 1'b1, 1'b0, 8'hC3, 8'h5A, 8, srx);
    check(srx == 8'h5A, "R10 output without select", int'(srx), 8'h5A);
    reg_read(2'd1, r);
    check(r == 8'h80, "R10 flag without select", int'(r), 8'h80);
    reg_read(2'd2, r);
    check(r == 8'hC3, "R10 received without select", int'(r), 8'hC3);

    // R11 ignore bit has no effect in phase 0
    slave_xfer(1'b0, 1'b0, 1'b1, 1'b0, 8'h96, 8'h2B, 8, srx);
    reg_read(2'd1, r);
    check(r == 8'h00, "R11 no flag", int'(r), 0);
    reg_read(2'd2, r);
    check(r == 8'h2B, "R11 preload untouched", int'(r), 8'h2B);

    // R12 abort mid-byte, then a full byte
    slave_xfer(1'b0, 1'b0, 1'b0, 1'b1, 8'hF0, 8'h11, 3, srx);
    reg_read(2'd1, r);
    check(r == 8'h00, "R12 no flag after abort", int'(r), 0);
    slave_xfer(1'b0, 1'b0, 1'b0, 1'b1, 8'h4E, 8'hD2, 8, srx);
    reg_read(2'd1, r);
    check(r == 8'h80, "R12 flag after full byte", int'(r), 8'h80);
    reg_read(2'd2, r);
    check(r == 8'h4E, "R12 byte after abort", int'(r), 8'h4E);
    check(srx == 8'hD2, "R12 output after abort", int'(srx), 8'hD2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule